// File: doc/BRIEF.md
# Framebuffer Transfer and Conversion Engine

This block copies a rendered image from an input buffer in memory to an output display buffer, one pixel at a time. During the copy it can reorder pixels between an 8x8 tiled layout and a plain row-major layout, mirror the image top to bottom, convert between five pixel formats, and halve the width by averaging pairs of neighbouring pixels.

Software sets up the job on the configuration inputs: two base addresses, two dimension words and a flags word. It then writes to the trigger register with bit 0 set. The engine captures the configuration at that write. It issues single-word reads and writes on a simple request/response memory port, with one access outstanding at a time. It reports busy while the job runs and pulses done when the job ends. Memory is addressed in 32-bit words and each pixel occupies one word, stored in its low bits.

Top module: `fbx_engine`

## Requirements
- R1: A base address input holds a physical address divided by 8. The word address of pixel offset k in a buffer is base*8 + k.
- R2: A dimension word carries the width in bits 15-0 and the height in bits 31-16. The job visits every output pixel in row-major order: x runs from 0 to outW-1 and y from 0 to outH-1. It writes exactly outW*outH words.
- R3: A trigger write starts a job only when trig_wdata bit 0 is 1 and the engine is idle. A trigger write with bit 0 clear, or any trigger write while busy, has no effect. The configuration is captured at the start, so changing the configuration inputs during a job has no effect on that job.
- R4: busy rises in the cycle after an accepted trigger and stays high until the final write is acknowledged. done then pulses for exactly one cycle while busy is low. If the output width or height is 0, done pulses right after the trigger and no memory access takes place.
- R5: Flag bit 0 mirrors the image vertically: output row y takes input row inH-1-y.
- R6: When flag bits 1 and 3 are both clear, the input is tiled and the output is linear. The tiled offset of (px,py) in a buffer of width W is ((py/8)*(W/8) + px/8)*64 + m. Here m interleaves the low three bits as {py2,px2,py1,px1,py0,px0}. The linear offset is py*W+px.
- R7: Flag bit 1 (with bit 3 clear) reads a linear input and writes a tiled output, using the R6 offsets.
- R8: Flag bit 3 selects a linear-to-linear copy and takes priority over bit 1.
- R9: Flag bits 10-8 give the input format and bits 14-12 give the output format. The word layouts are:
  - 0: {R8,G8,B8,A8}.
  - 1: {8'h0,R8,G8,B8}.
  - 2: low 16 bits {R5,G6,B5}.
  - 3: low 16 bits {R5,G5,B5,A1}.
  - 4: low 16 bits {R4,G4,B4,A4}.
  - Codes 5-7 behave as code 0.
  - Unused upper bits are written as 0.
- R10: Decoding widens a channel to 8 bits by repeating its bits from the MSB down. A 1-bit alpha becomes 0 or 255. Formats without alpha decode to alpha 255. Encoding keeps the top bits of each channel.
- R11: Flag bit 24 halves the width. Output pixel x averages input pixels 2x and 2x+1 of the same row, per 8-bit channel, as (a+b+1)>>1. Flag bit 2 is informational and has no effect.
- R12: Reads and writes never overlap. A request holds its address and data stable until it is answered by rd_vld or wr_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_base | input | 29 | Input buffer address divided by 8 |
| cfg_out_base | input | 29 | Output buffer address divided by 8 |
| cfg_in_dim | input | 32 | Input {height, width} |
| cfg_out_dim | input | 32 | Output {height, width} |
| cfg_flags | input | 32 | Mode and format flags |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 32 | Trigger write data; bit 0 starts a job |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read word address |
| rd_vld | input | 1 | Read data valid; completes the read |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write word address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench covers the Morton order inside tiles and the tile-row stride, in both the tiled-to-linear and linear-to-tiled directions. A swapped interleave or a wrong stride writes pixels to scrambled addresses. Two jobs set bits 1 and 3 together, or combine mirroring with halving. A wrong priority shows up as tiled output addresses, and a wrong flip base shows up as rows read from the wrong end. Format jobs expand 5-, 6-, 4- and 1-bit channels, check the forced alpha, and use averaging inputs whose sums are odd, so truncation or a missing rounding bit changes the data. Further checks cover a zero-height job, a trigger with bit 0 clear, and a retrigger during a job with the configuration inputs scrambled. A design that reacts to any of these issues stray reads or writes, or fails to return done.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  localparam int DIM_W   = 16;
  localparam int ADDR_W  = 32;
  localparam int BASE_W  = ADDR_W - 3;
  localparam int FMT_W   = 3;
  localparam int TILE_LG = 3;

  localparam int FLG_FLIP  = 0;
  localparam int FLG_TILE  = 1;
  localparam int FLG_RAW   = 3;
  localparam int FLG_IFMT  = 8;
  localparam int FLG_OFMT  = 12;
  localparam int FLG_HALVE = 24;

  typedef enum logic [1:0] {LAY_T2L, LAY_L2T, LAY_RAW} layout_e;

  typedef struct packed {
    logic [BASE_W-1:0] in_base;
    logic [BASE_W-1:0] out_base;
    logic [DIM_W-1:0]  in_w;
    logic [DIM_W-1:0]  in_h;
    logic [DIM_W-1:0]  out_w;
    logic [DIM_W-1:0]  out_h;
    logic              flip;
    logic              halve;
    layout_e           layout;
    logic [FMT_W-1:0]  in_fmt;
    logic [FMT_W-1:0]  out_fmt;
  } job_cfg_t;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [7:0] a;
  } rgba_t;

  function automatic logic [ADDR_W-1:0] tile_off(input logic [DIM_W-1:0] px,
                                                 input logic [DIM_W-1:0] py,
                                                 input logic [DIM_W-1:0] w);
    logic [ADDR_W-1:0] t;
    t = ADDR_W'(py >> TILE_LG) * ADDR_W'(w >> TILE_LG) + ADDR_W'(px >> TILE_LG);
    return {t[ADDR_W-7:0], py[2], px[2], py[1], px[1], py[0], px[0]};
  endfunction

  function automatic rgba_t pix_decode(input logic [FMT_W-1:0] f, input logic [31:0] p);
    rgba_t c;
    case (f)
      3'd1: c = '{r: p[23:16], g: p[15:8], b: p[7:0], a: 8'hFF};
      3'd2: c = '{r: {p[15:11], p[15:13]}, g: {p[10:5], p[10:9]},
                  b: {p[4:0], p[4:2]}, a: 8'hFF};
      3'd3: c = '{r: {p[15:11], p[15:13]}, g: {p[10:6], p[10:8]},
                  b: {p[5:1], p[5:3]}, a: {8{p[0]}}};
      3'd4: c = '{r: {2{p[15:12]}}, g: {2{p[11:8]}}, b: {2{p[7:4]}}, a: {2{p[3:0]}}};
      default: c = '{r: p[31:24], g: p[23:16], b: p[15:8], a: p[7:0]};
    endcase
    return c;
  endfunction

  function automatic logic [31:0] pix_encode(input logic [FMT_W-1:0] f, input rgba_t c);
    logic [31:0] p;
    case (f)
      3'd1: p = {8'h00, c.r, c.g, c.b};
      3'd2: p = {16'h0000, c.r[7:3], c.g[7:2], c.b[7:3]};
      3'd3: p = {16'h0000, c.r[7:3], c.g[7:3], c.b[7:3], c.a[7]};
      3'd4: p = {16'h0000, c.r[7:4], c.g[7:4], c.b[7:4], c.a[7:4]};
      default: p = {c.r, c.g, c.b, c.a};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/fbx_addr.sv
module fbx_addr
  import fbx_pkg::*;
(
  input  job_cfg_t          cfg,
  input  logic [DIM_W-1:0]  x,
  input  logic [DIM_W-1:0]  y,
  input  logic              second,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  logic [DIM_W-1:0]  sx, sy;
  logic [ADDR_W-1:0] src_off, dst_off;

  always_comb begin
    sx = cfg.halve ? {x[DIM_W-2:0], second} : x;
    sy = cfg.flip ? (cfg.in_h - DIM_W'(1) - y) : y;
    if (cfg.layout == LAY_T2L) src_off = tile_off(sx, sy, cfg.in_w);
    else                       src_off = ADDR_W'(sy) * ADDR_W'(cfg.in_w) + ADDR_W'(sx);
    if (cfg.layout == LAY_L2T) dst_off = tile_off(x, y, cfg.out_w);
    else                       dst_off = ADDR_W'(y) * ADDR_W'(cfg.out_w) + ADDR_W'(x);
    src_addr = {cfg.in_base, 3'b000} + src_off;
    dst_addr = {cfg.out_base, 3'b000} + dst_off;
  end
endmodule

// File: rtl/fbx_pixconv.sv
module fbx_pixconv
  import fbx_pkg::*;
(
  input  logic [FMT_W-1:0] in_fmt,
  input  logic [FMT_W-1:0] out_fmt,
  input  logic             halve,
  input  logic [31:0]      pix_a,
  input  logic [31:0]      pix_b,
  output logic [31:0]      pix_out
);
  rgba_t ca, cb, cm;
  logic [8:0] sum [4];

  always_comb begin
    ca = pix_decode(in_fmt, pix_a);
    cb = pix_decode(in_fmt, pix_b);
    for (int i = 0; i < 4; i++) begin
      sum[i] = {1'b0, ca[8*i +: 8]} + {1'b0, cb[8*i +: 8]} + 9'd1;
      cm[8*i +: 8] = halve ? sum[i][8:1] : ca[8*i +: 8];
    end
    pix_out = pix_encode(out_fmt, cm);
  end
endmodule

// File: rtl/fbx_engine.sv
module fbx_engine
  import fbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] cfg_in_base,
  input  logic [BASE_W-1:0] cfg_out_base,
  input  logic [31:0]       cfg_in_dim,
  input  logic [31:0]       cfg_out_dim,
  input  logic [31:0]       cfg_flags,
  input  logic              trig_we,
  input  logic [31:0]       trig_wdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_vld,
  input  logic [31:0]       rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD_A, ST_RD_B, ST_WR} st_e;

  st_e              st_q, st_d;
  logic [DIM_W-1:0] x_q, x_d, y_q, y_d;
  logic [31:0]      pa_q, pb_q;
  logic             pa_en, pb_en, cfg_en;
  logic             done_q, done_d;
  job_cfg_t         cfg_q, cfg_new;
  logic             start, empty, last_x, last_y;

  always_comb begin
    cfg_new.in_base  = cfg_in_base;
    cfg_new.out_base = cfg_out_base;
    cfg_new.in_w     = cfg_in_dim[DIM_W-1:0];
    cfg_new.in_h     = cfg_in_dim[2*DIM_W-1:DIM_W];
    cfg_new.out_w    = cfg_out_dim[DIM_W-1:0];
    cfg_new.out_h    = cfg_out_dim[2*DIM_W-1:DIM_W];
    cfg_new.flip     = cfg_flags[FLG_FLIP];
    cfg_new.halve    = cfg_flags[FLG_HALVE];
    cfg_new.layout   = cfg_flags[FLG_RAW]  ? LAY_RAW :
                       cfg_flags[FLG_TILE] ? LAY_L2T : LAY_T2L;
    cfg_new.in_fmt   = cfg_flags[FLG_IFMT +: FMT_W];
    cfg_new.out_fmt  = cfg_flags[FLG_OFMT +: FMT_W];
  end

  assign start  = trig_we && trig_wdata[0] && (st_q == ST_IDLE);
  assign empty  = (cfg_new.out_w == '0) || (cfg_new.out_h == '0);
  assign last_x = (x_q == cfg_q.out_w - DIM_W'(1));
  assign last_y = (y_q == cfg_q.out_h - DIM_W'(1));

  always_comb begin
    st_d   = st_q;
    x_d    = x_q;
    y_d    = y_q;
    done_d = 1'b0;
    pa_en  = 1'b0;
    pb_en  = 1'b0;
    cfg_en = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        if (empty) begin
          done_d = 1'b1;
        end else begin
          cfg_en = 1'b1;
          x_d    = '0;
          y_d    = '0;
          st_d   = ST_RD_A;
        end
      end
      ST_RD_A: if (rd_vld) begin
        pa_en = 1'b1;
        st_d  = cfg_q.halve ? ST_RD_B : ST_WR;
      end
      ST_RD_B: if (rd_vld) begin
        pb_en = 1'b1;
        st_d  = ST_WR;
      end
      ST_WR: if (wr_ack) begin
        st_d = ST_RD_A;
        if (!last_x) begin
          x_d = x_q + DIM_W'(1);
        end else begin
          x_d = '0;
          if (last_y) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            y_d = y_q + DIM_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      done_q <= 1'b0;
      pa_q   <= '0;
      pb_q   <= '0;
      cfg_q  <= '0;
    end else begin
      st_q   <= st_d;
      x_q    <= x_d;
      y_q    <= y_d;
      done_q <= done_d;
      if (pa_en)  pa_q  <= rd_data;
      if (pb_en)  pb_q  <= rd_data;
      if (cfg_en) cfg_q <= cfg_new;
    end
  end

  fbx_addr u_addr (
    .cfg      (cfg_q),
    .x        (x_q),
    .y        (y_q),
    .second   (st_q == ST_RD_B),
    .src_addr (rd_addr),
    .dst_addr (wr_addr)
  );

  fbx_pixconv u_conv (
    .in_fmt  (cfg_q.in_fmt),
    .out_fmt (cfg_q.out_fmt),
    .halve   (cfg_q.halve),
    .pix_a   (pa_q),
    .pix_b   (pb_q),
    .pix_out (wr_data)
  );

  assign rd_req = (st_q == ST_RD_A) || (st_q == ST_RD_B);
  assign wr_req = (st_q == ST_WR);
  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_vld |=> rd_req && $stable(rd_addr));
  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));
  // R12
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we && trig_wdata[0] && !busy && (cfg_out_dim[15:0] != 16'd0)
    && (cfg_out_dim[31:16] != 16'd0) |=> busy);
  // R3
  nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(trig_we && trig_wdata[0]) |=> !busy);
endmodule

// File: tb/fbx_engine_tb.sv
module fbx_engine_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MEM_WORDS  = 4096;
  localparam int  IN_BASE    = 16;
  localparam int  OUT_BASE   = 256;

  logic        clk, rst_n;
  logic [28:0] cfg_in_base, cfg_out_base;
  logic [31:0] cfg_in_dim, cfg_out_dim, cfg_flags;
  logic        trig_we;
  logic [31:0] trig_wdata;
  logic        rd_req, rd_vld, wr_req, wr_ack, busy, done;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;

  logic [31:0] mem [MEM_WORDS];
  int checks, errors, rd_seen, wr_seen, cyc;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t sb[$];

  fbx_engine u_dut (.*);

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Memory model and scoreboard monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req) rd_seen++;
      if (rd_req && !rd_vld) begin
        rd_data <= mem[rd_addr[11:0]];
        rd_vld  <= 1'b1;
      end else begin
        rd_vld  <= 1'b0;
      end
      if (wr_req && !wr_ack) begin
        wr_seen++;
        mem[wr_addr[11:0]] = wr_data;
        wr_ack <= 1'b1;
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected write", wr_addr, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(wr_addr == e.a, {e.tag, " addr"}, wr_addr, e.a);
          chk(wr_data == e.d, {e.tag, " data"}, wr_data, e.d);
        end
      end else begin
        wr_ack <= 1'b0;
      end
    end
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  function automatic logic [7:0] widen(int v, int bits);
    if (bits == 1) return (v != 0) ? 8'hFF : 8'h00;
    return 8'(((v << (8 - bits)) | (v >> (2 * bits - 8))) & 255);
  endfunction

  function automatic logic [31:0] b_dec(int f, logic [31:0] p);
    int r, g, b, a;
    case (f)
      1: begin r = p[23:16]; g = p[15:8]; b = p[7:0]; a = 255; end
      2: begin r = widen(p[15:11], 5); g = widen(p[10:5], 6); b = widen(p[4:0], 5); a = 255; end
      3: begin r = widen(p[15:11], 5); g = widen(p[10:6], 5); b = widen(p[5:1], 5); a = widen(p[0], 1); end
      4: begin r = widen(p[15:12], 4); g = widen(p[11:8], 4); b = widen(p[7:4], 4); a = widen(p[3:0], 4); end
      default: begin r = p[31:24]; g = p[23:16]; b = p[15:8]; a = p[7:0]; end
    endcase
    return {8'(r), 8'(g), 8'(b), 8'(a)};
  endfunction

  function automatic logic [31:0] b_enc(int f, logic [31:0] c);
    int r, g, b, a;
    r = c[31:24]; g = c[23:16]; b = c[15:8]; a = c[7:0];
    case (f)
      1: return {8'h0, 8'(r), 8'(g), 8'(b)};
      2: return 32'((r / 8) * 2048 + (g / 4) * 32 + b / 8);
      3: return 32'((r / 8) * 2048 + (g / 8) * 64 + (b / 8) * 2 + a / 128);
      4: return 32'((r / 16) * 4096 + (g / 16) * 256 + (b / 16) * 16 + a / 16);
      default: return c;
    endcase
  endfunction

  function automatic int b_tile(int px, int py, int w);
    int m;
    m = (px & 1) | ((py & 1) << 1) | ((px & 2) << 1) | ((py & 2) << 2) | ((px & 4) << 2) | ((py & 4) << 3);
    return ((py / 8) * (w / 8) + px / 8) * 64 + m;
  endfunction

  // Driver: compute the expected writes of a job and start it.
  task automatic run_job(int iw, int ih, int ow, int oh, logic [31:0] flags, string tag);
    bit flip, halve;
    int lay, fi, fo, cyc0;
    flip  = flags[0];
    halve = flags[24];
    lay   = flags[3] ? 2 : (flags[1] ? 1 : 0);
    fi    = flags[10:8];
    fo    = flags[14:12];
    for (int y = 0; y < oh; y++) begin
      for (int x = 0; x < ow; x++) begin
        int sy, io, io2, oo;
        logic [31:0] c0, c1, cm;
        exp_t e;
        sy  = flip ? ih - 1 - y : y;
        io  = (lay == 0) ? b_tile(halve ? 2 * x : x, sy, iw) : sy * iw + (halve ? 2 * x : x);
        io2 = (lay == 0) ? b_tile(2 * x + 1, sy, iw) : sy * iw + 2 * x + 1;
        oo  = (lay == 1) ? b_tile(x, y, ow) : y * ow + x;
        c0  = b_dec(fi, mem[IN_BASE * 8 + io]);
        cm  = c0;
        if (halve) begin
          c1 = b_dec(fi, mem[IN_BASE * 8 + io2]);
          for (int k = 0; k < 4; k++) cm[8*k +: 8] = 8'((int'(c0[8*k +: 8]) + int'(c1[8*k +: 8]) + 1) / 2);
        end
        e.a = 32'(OUT_BASE * 8 + oo);
        e.d = b_enc(fo, cm);
        e.tag = tag;
        sb.push_back(e);
      end
    end
    cfg_in_base  = 29'(IN_BASE);
    cfg_out_base = 29'(OUT_BASE);
    cfg_in_dim   = {16'(ih), 16'(iw)};
    cfg_out_dim  = {16'(oh), 16'(ow)};
    cfg_flags    = flags;
    wr_seen = 0;
    @(negedge clk);
    trig_we = 1'b1; trig_wdata = 32'h1;
    @(negedge clk);
    trig_we = 1'b0; trig_wdata = 32'h0;
    if (ow * oh != 0) chk(busy == 1'b1, {tag, " R4 busy after trigger"}, 32'(busy), 32'h1);
    cyc0 = cyc;
    while (!done && (cyc - cyc0) < 20000) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, {tag, " R4 done with busy low"}, {busy, done}, 32'h1);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R4 done one cycle"}, 32'(done), 32'h0);
    chk(sb.size() == 0, {tag, " R2 all writes seen"}, 32'(sb.size()), 32'h0);
    chk(wr_seen == ow * oh, {tag, " R2 write count"}, 32'(wr_seen), 32'(ow * oh));
  endtask

  initial begin
    checks = 0; errors = 0; rd_seen = 0; wr_seen = 0;
    rst_n = 1'b0;
    trig_we = 1'b0; trig_wdata = '0;
    rd_vld = 1'b0; rd_data = '0; wr_ack = 1'b0;
    cfg_in_base = '0; cfg_out_base = '0; cfg_in_dim = '0; cfg_out_dim = '0; cfg_flags = '0;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'(i) * 32'h9E3779B1 + 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_req && !wr_req, "R4 reset idle", {busy, done, rd_req, wr_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    run_job(16, 16, 16, 16, 32'h0000_0000, "R6 R1 tiled-to-linear");
    run_job(8, 16, 8, 16, 32'h0000_0203, "R7 R5 R10 linear-to-tiled flip 565");
    run_job(8, 4, 8, 4, 32'h0000_340A, "R8 R9 raw priority 4444->5551");
    run_job(16, 8, 8, 8, 32'h0100_4104, "R11 R10 halve tiled rgb8->4444");
    run_job(8, 2, 4, 2, 32'h0100_1309, "R11 R5 halve flip raw 5551->rgb8");
    run_job(8, 8, 8, 8, 32'h0000_2000, "R9 rgba8->565");

    // R4: zero output height ends at once, no access.
    rd_seen = 0;
    run_job(8, 8, 8, 0, 32'h0000_0008, "R4 empty job");
    chk(rd_seen == 0, "R4 empty job no reads", 32'(rd_seen), 32'h0);

    // R3: trigger with bit 0 clear is ignored.
    rd_seen = 0;
    cfg_out_dim = {16'd4, 16'd8};
    @(negedge clk); trig_we = 1'b1; trig_wdata = 32'hFFFF_FFFE;
    @(negedge clk); trig_we = 1'b0; trig_wdata = 32'h0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && rd_seen == 0, "R3 bit0 clear ignored", {busy, 31'(rd_seen)}, 32'h0);

    // R3: retrigger while busy with scrambled configuration is ignored.
    fork
      run_job(8, 8, 8, 8, 32'h0000_000A, "R3 retrigger during job");
      begin
        repeat (6) @(negedge clk);
        cfg_in_base = 29'd99; cfg_out_base = 29'd77;
        cfg_in_dim = 32'h0003_0005; cfg_out_dim = 32'h0002_0003; cfg_flags = 32'h0100_0001;
        trig_we = 1'b1; trig_wdata = 32'h1;
        @(negedge clk); trig_we = 1'b0; trig_wdata = 32'h0;
      end
    join
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && sb.size() == 0, "R3 no job after retrigger", {busy, 31'(sb.size())}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule